// File: doc/BRIEF.md
# Synchronous Serial Port Master

This block is a serial-peripheral master port. Software talks to it over a small word-addressed register bus. It queues outgoing frames in a transmit FIFO and shifts each one out MSB first on `mosi_o`, with `sclk_o` as the serial clock. While a frame goes out, it shifts the incoming line into a receive FIFO, so every frame sent gives exactly one frame received. Frames are 4 to 16 bits wide. Clock polarity and clock phase are set in a control register.

The serial clock half-period comes from an internal divider. It uses a prescale value (even, with bit 0 ignored) and a rate divisor, both in registers. A loopback mode ties the shifter's output to its own input for self-test. A single interrupt line combines three gated sources: a receive level source, a transmit level source and a sticky receive-overrun source.

Register map (byte offsets, decoded on `bus_addr[4:2]`):
- 0x00 format: bits 3:0 hold the frame width minus one, bit 6 is the clock phase, bit 7 is the clock polarity, bits 15:8 hold the rate divisor.
- 0x04 control: bit 0 is the receive interrupt enable, bit 1 the transmit interrupt enable, bit 2 the overrun interrupt enable, bit 3 loopback, bit 4 port enable. Bits 5 and 6 are stored only.
- 0x08 data: a write pushes the transmit FIFO; a read pops the receive FIFO.
- 0x0C status: bit 0 is transmit FIFO empty, bit 1 transmit FIFO not full, bit 2 receive FIFO not empty, bit 3 receive FIFO full, bit 4 frame in progress.
- 0x10 prescale: bits 7:1.
- 0x14 interrupt status on read: bit 0 receive, bit 1 transmit, bit 2 overrun. A write of any value clears the overrun flag.

Top module: `ssp_master`

## Requirements
- R1: After reset the port is disabled, status reads 0x03, interrupt status reads 0, `irq_o` is 0, `sclk_o` is 0 and `mosi_o` is 0. While no frame is in progress, `sclk_o` sits at the programmed polarity.
- R2: In loopback, each written frame is read back equal to the written value masked to the frame width, for every width from 4 to 16 and all four polarity/phase settings.
- R3: Frames leave MSB first. With phase 0, `mosi_o` is valid at the clock edge leading away from the idle level. With phase 1, it is valid at the returning edge. There is exactly one such edge per bit.
- R4: Received frames are right-justified and zero-extended to 16 bits. With `miso_i` held at 1, a frame reads back as 2^width - 1.
- R5: Each FIFO holds 8 frames. A data write to a full transmit FIFO is dropped, and status then reads 0x00 while the port is disabled.
- R6: A frame that completes while the receive FIFO is full is discarded and sets the overrun flag. The flag stays set until any write to offset 0x14.
- R7: The receive source is active when the receive FIFO holds at least 4 frames. The transmit source is active when the transmit FIFO holds at most 4 frames. Each source is gated by its enable bit, and `irq_o` is their OR.
- R8: While the port enable is 0, no frame starts, `sclk_o` does not move and the status busy bit is 0. Clearing the enable aborts a frame in progress.
- R9: The serial half-period is max(prescale/2, 1) x (divisor + 1) clock cycles. A frame of W bits written at a clock edge shows in status bit 2 exactly 2·W·half + 1 edges later.
- R10: A width code below 3 selects 4-bit frames.
- R11: Control bits 5 and 6 read back as written and have no effect on master operation.
- R12: In loopback, `mosi_o` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Combined interrupt |

## Verification
A data write is taken at a clock edge. The shifter loads the frame on the next edge. The received frame is pushed on the edge of the final half-period tick, so status bit 2 rises exactly 2·W·half + 1 edges after the write. The timing check reads status one edge before that point and again at that point. Register reads are combinational and are sampled 1 ns after an edge, so each read shows the state left by that edge. Pops and writes take effect at the next edge. The functional sweeps wait 2·W + 4 edges at a half-period of one cycle, or a fixed margin over 8 frames, before they read back.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
   typedef enum logic [2:0] {
      IDX_FMT  = 3'd0,
      IDX_CTL  = 3'd1,
      IDX_DATA = 3'd2,
      IDX_STAT = 3'd3,
      IDX_PRE  = 3'd4,
      IDX_IRQ  = 3'd5
   } reg_idx_e;

   localparam int CTL_RXIE = 0;
   localparam int CTL_TXIE = 1;
   localparam int CTL_OVIE = 2;
   localparam int CTL_LOOP = 3;
   localparam int CTL_EN   = 4;
   localparam int FMT_PHA  = 6;
   localparam int FMT_POL  = 7;
endpackage

// File: rtl/ssp_fifo.sv
`timescale 1ns/1ps
module ssp_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [W-1:0]                 wdata,
   input  logic                         pop,
   output logic [W-1:0]                 rdata,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         empty,
   output logic                         full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH+1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign rdata   = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/ssp_clkgen.sv
`timescale 1ns/1ps
module ssp_clkgen #(
   parameter int PRE_W = 7,
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] pre,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int CNT_W = PRE_W + DIV_W + 1;

   logic [CNT_W-1:0] half, cnt;
   logic [CNT_W-1:0] pre_eff;

   always_comb begin
      pre_eff = (pre == '0) ? CNT_W'(1) : CNT_W'(pre);
      half    = pre_eff * (CNT_W'(div) + 1'b1);
   end

   assign tick = run && (cnt == half - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (tick)   cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ssp_shifter.sv
`timescale 1ns/1ps
module ssp_shifter #(
   parameter int FW    = 16,
   parameter int WID_W = $clog2(FW+1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             cpol,
   input  logic             cpha,
   input  logic [WID_W-1:0] width,
   input  logic             tx_valid,
   input  logic [FW-1:0]    tx_data,
   output logic             tx_pop,
   input  logic             tick,
   input  logic             sdi,
   output logic             sdo,
   output logic             sclk,
   output logic             rx_push,
   output logic [FW-1:0]    rx_data,
   output logic             busy
);
   localparam int HC_W = $clog2(2*FW);

   logic [FW-1:0]    sr_tx, sr_rx, mask;
   logic [FW:0]      m_full;
   logic [HC_W-1:0]  half_q;
   logic [WID_W-1:0] width_q;
   logic             cpha_q, sample, last;

   assign sample = ~half_q[0] ^ cpha_q;
   assign last   = (WID_W'(half_q >> 1) == width_q - 1'b1) && half_q[0];
   assign tx_pop = en && !busy && tx_valid;
   assign sdo    = busy ? sr_tx[FW-1] : 1'b0;
   assign m_full = (FW+1)'(1) << width_q;
   assign mask   = FW'(m_full - 1'b1);
   assign rx_push = en && busy && tick && last;
   assign rx_data = (cpha_q ? {sr_rx[FW-2:0], sdi} : sr_rx) & mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         sclk    <= 1'b0;
         half_q  <= '0;
         sr_tx   <= '0;
         sr_rx   <= '0;
         width_q <= WID_W'(4);
         cpha_q  <= 1'b0;
      end else if (!en) begin
         busy <= 1'b0;
         sclk <= cpol;
      end else if (!busy) begin
         sclk <= cpol;
         if (tx_valid) begin
            busy    <= 1'b1;
            half_q  <= '0;
            sr_rx   <= '0;
            width_q <= width;
            cpha_q  <= cpha;
            sr_tx   <= tx_data << (FW - int'(width));
         end
      end else if (tick) begin
         sclk   <= ~sclk;
         half_q <= half_q + 1'b1;
         if (sample)
            sr_rx <= {sr_rx[FW-2:0], sdi};
         else if (!(cpha_q && half_q == '0))
            sr_tx <= sr_tx << 1;
         if (last) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/ssp_master.sv
`timescale 1ns/1ps
module ssp_master
   import ssp_pkg::*;
#(
   parameter int FW      = 16,
   parameter int DEPTH   = 8,
   parameter int ADDR_W  = 5,
   parameter int IRQ_LVL = DEPTH / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              sclk_o,
   output logic              mosi_o,
   input  logic              miso_i,
   output logic              irq_o
);
   localparam int DATA_W = 16;
   localparam int CNT_W  = $clog2(DEPTH+1);
   localparam int WID_W  = $clog2(FW+1);

   generate
      if (FW < 4 || FW > DATA_W) begin : g_bad_fw
         $error("ssp_master: FW must lie in 4..16");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("ssp_master: DEPTH must be at least 2");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ssp_master: ADDR_W must be at least 5");
      end
      if (IRQ_LVL < 1 || IRQ_LVL > DEPTH) begin : g_bad_lvl
         $error("ssp_master: IRQ_LVL out of range");
      end
   endgenerate

   logic [15:0]      cr0_q;
   logic [6:0]       cr1_q;
   logic [6:0]       pre_q;
   logic             ovr_q;

   reg_idx_e         idx;
   logic             wr_en, rd_en, ovr_clr;
   logic             port_en, loop_en;
   logic [WID_W-1:0] eff_w;

   logic             tx_push, tx_pop, tx_empty, tx_full;
   logic [FW-1:0]    tx_head;
   logic [CNT_W-1:0] tx_cnt;
   logic             rx_push, rx_pop, rx_empty, rx_full;
   logic [FW-1:0]    rx_head, rx_frame;
   logic [CNT_W-1:0] rx_cnt;

   logic             half_tick, shift_busy, sdo, sdi, sclk_int;
   logic [2:0]       isr;

   assign idx     = reg_idx_e'(bus_addr[4:2]);
   assign wr_en   = bus_sel & bus_wr;
   assign rd_en   = bus_sel & ~bus_wr;
   assign ovr_clr = wr_en && idx == IDX_IRQ;
   assign port_en = cr1_q[CTL_EN];
   assign loop_en = cr1_q[CTL_LOOP];
   assign tx_push = wr_en && idx == IDX_DATA;
   assign rx_pop  = rd_en && idx == IDX_DATA;

   always_comb begin
      if (cr0_q[3:0] < 4'd3)
         eff_w = WID_W'(4);
      else if (int'(cr0_q[3:0]) + 1 > FW)
         eff_w = WID_W'(FW);
      else
         eff_w = WID_W'(cr0_q[3:0]) + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cr0_q <= '0;
         cr1_q <= '0;
         pre_q <= '0;
      end else if (wr_en) begin
         case (idx)
            IDX_FMT: cr0_q <= {bus_wdata[15:6], 2'b00, bus_wdata[3:0]};
            IDX_CTL: cr1_q <= bus_wdata[6:0];
            IDX_PRE: pre_q <= bus_wdata[7:1];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ovr_q <= 1'b0;
      else if (rx_push && rx_full) ovr_q <= 1'b1;
      else if (ovr_clr)            ovr_q <= 1'b0;
   end

   ssp_fifo #(.W(FW), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata[FW-1:0]),
      .pop(tx_pop), .rdata(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
   );

   ssp_fifo #(.W(FW), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_frame),
      .pop(rx_pop), .rdata(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
   );

   ssp_clkgen #(.PRE_W(7), .DIV_W(8)) u_div (
      .clk(clk), .rst_n(rst_n), .run(shift_busy & port_en),
      .pre(pre_q), .div(cr0_q[15:8]), .tick(half_tick)
   );

   assign sdi = loop_en ? sdo : miso_i;

   ssp_shifter #(.FW(FW), .WID_W(WID_W)) u_shf (
      .clk(clk), .rst_n(rst_n), .en(port_en),
      .cpol(cr0_q[FMT_POL]), .cpha(cr0_q[FMT_PHA]), .width(eff_w),
      .tx_valid(~tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
      .tick(half_tick), .sdi(sdi), .sdo(sdo), .sclk(sclk_int),
      .rx_push(rx_push), .rx_data(rx_frame), .busy(shift_busy)
   );

   assign sclk_o = sclk_int;
   assign mosi_o = loop_en ? 1'b0 : sdo;

   assign isr[0] = cr1_q[CTL_RXIE] && (rx_cnt >= CNT_W'(IRQ_LVL));
   assign isr[1] = cr1_q[CTL_TXIE] && (tx_cnt <= CNT_W'(IRQ_LVL));
   assign isr[2] = cr1_q[CTL_OVIE] && ovr_q;
   assign irq_o  = |isr;

   always_comb begin
      case (idx)
         IDX_FMT:  bus_rdata = cr0_q;
         IDX_CTL:  bus_rdata = DATA_W'(cr1_q);
         IDX_DATA: bus_rdata = rx_empty ? '0 : DATA_W'(rx_head);
         IDX_STAT: bus_rdata = DATA_W'({shift_busy, rx_full, ~rx_empty, ~tx_full, tx_empty});
         IDX_PRE:  bus_rdata = DATA_W'({pre_q, 1'b0});
         IDX_IRQ:  bus_rdata = DATA_W'(isr);
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ssp_master_chk.sv
`timescale 1ns/1ps
module ssp_master_chk #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             loop,
   input logic             busy,
   input logic             tick,
   input logic             sclk,
   input logic             cpol,
   input logic             mosi,
   input logic             ovr,
   input logic             clr,
   input logic [CNT_W-1:0] rx_cnt,
   input logic [CNT_W-1:0] tx_cnt
);
   // R1
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> sclk == $past(cpol));

   // R12
   loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loop |-> !mosi);

   // R6
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr && !clr |=> ovr);

   // R5
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt <= CNT_W'(DEPTH) && tx_cnt <= CNT_W'(DEPTH));

   // R8
   halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy);

   // R9
   edge_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && en && !tick |=> $stable(sclk));
endmodule

bind ssp_master ssp_master_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(port_en), .loop(loop_en), .busy(shift_busy),
   .tick(half_tick), .sclk(sclk_o), .cpol(cr0_q[7]), .mosi(mosi_o),
   .ovr(ovr_q), .clr(ovr_clr), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt)
);

// File: tb/sim_ssp_master.sv
`timescale 1ns/1ps
module sim_ssp_master;
   localparam logic [4:0] A_FMT = 5'h00, A_CTL = 5'h04, A_DAT = 5'h08,
                          A_STS = 5'h0C, A_PRE = 5'h10, A_ISR = 5'h14;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        sel = 1'b0, wr = 1'b0, miso = 1'b0;
   logic [4:0]  addr = '0;
   logic [15:0] wdata = '0, rdata;
   logic        sclk_o, mosi_o, irq_o;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   ssp_master u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .sclk_o(sclk_o), .mosi_o(mosi_o),
      .miso_i(miso), .irq_o(irq_o)
   );

   // mosi capture at the mode's sampling edge
   bit cap_en = 0, cap_pol = 0, cap_pha = 0;
   logic [15:0] cap = '0;
   int cap_n = 0;
   always @(sclk_o) if (cap_en) begin
      if ((sclk_o != cap_pol) ^ cap_pha) begin
         cap = {cap[14:0], mosi_o};
         cap_n++;
      end
   end

   bit loop_mon = 0, mosi_bad = 0, dis_mon = 0;
   int sclk_moves = 0;
   always @(posedge clk) if (loop_mon && mosi_o) mosi_bad = 1;
   always @(sclk_o) if (dis_mon) sclk_moves++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      sel = 1; wr = 1; addr = a; wdata = d;
      @(posedge clk); #1;
      sel = 0; wr = 0;
   endtask

   task automatic peek(input logic [4:0] a, output logic [15:0] d);
      sel = 1; wr = 0; addr = a;
      #0.5 d = rdata;
      sel = 0;
   endtask

   task automatic popd(output logic [15:0] d);
      @(negedge clk);
      sel = 1; wr = 0; addr = A_DAT;
      #0.5 d = rdata;
      @(posedge clk); #1;
      sel = 0;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #(100000 * 5);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [15:0] d, p, m;
      cyc(3);
      rst_n = 1;
      cyc(1);
      // R1 reset state
      peek(A_STS, d); chk("R1 status", d, 16'h0003);
      peek(A_ISR, d); chk("R1 isr", d, 16'h0000);
      chk("R1 irq/sclk/mosi", {irq_o, sclk_o, mosi_o}, 3'b000);

      // R2 loopback sweep, half-period 1
      wreg(A_PRE, 16'd2);
      wreg(A_CTL, 16'h0018);
      loop_mon = 1;
      for (int md = 0; md < 4; md++) begin
         for (int w = 4; w <= 16; w++) begin
            wreg(A_FMT, 16'((md << 6) | (w - 1)));
            p = 16'hC3A5 ^ 16'(w * 16'h0101) ^ 16'(md);
            m = 16'((32'd1 << w) - 1);
            wreg(A_DAT, p);
            cyc(2 * w + 4);
            popd(d);
            chk($sformatf("R2 mode%0d w%0d", md, w), d, p & m);
         end
      end
      loop_mon = 0;
      chk("R12 mosi idle in loopback", mosi_bad, 1'b0);

      // R3 / R4 external lines, miso held high
      miso = 1;
      wreg(A_CTL, 16'h0010);
      for (int md = 0; md < 4; md++) begin
         for (int k = 0; k < 2; k++) begin
            automatic int w = k ? 12 : 8;
            wreg(A_FMT, 16'((md << 6) | (w - 1)));
            cyc(3);
            p = 16'h9A6D ^ 16'(md * 16'h1111);
            m = 16'((32'd1 << w) - 1);
            cap_pol = md[1]; cap_pha = md[0]; cap = '0; cap_n = 0; cap_en = 1;
            wreg(A_DAT, p);
            cyc(2 * w + 4);
            cap_en = 0;
            chk($sformatf("R3 edges mode%0d w%0d", md, w), cap_n, w);
            chk($sformatf("R3 bits mode%0d w%0d", md, w), cap & m, p & m);
            popd(d);
            chk($sformatf("R4 rx mode%0d w%0d", md, w), d, m);
         end
      end
      miso = 0;
      wreg(A_FMT, 16'h0007);
      cyc(3);

      // R9 exact timing: half = (4/2)*(2+1) = 6, W = 8 -> flag after 97 edges
      wreg(A_PRE, 16'd4);
      wreg(A_FMT, 16'h0207);
      wreg(A_CTL, 16'h0018);
      wreg(A_DAT, 16'h00A5);
      cyc(96);
      peek(A_STS, d); chk("R9 not yet received", d[2], 1'b0);
      cyc(1);
      peek(A_STS, d); chk("R9 received on time", d[2], 1'b1);
      popd(d); chk("R9 data", d, 16'h00A5);
      wreg(A_PRE, 16'd2);
      wreg(A_FMT, 16'h0007);

      // R5 / R7 / R8 fill while disabled
      wreg(A_CTL, 16'h000B);
      dis_mon = 1; sclk_moves = 0;
      for (int i = 1; i <= 9; i++) begin
         wreg(A_DAT, 16'(i));
         if (i == 4) begin peek(A_ISR, d); chk("R7 tx level 4", d, 16'h0002); end
         if (i == 5) begin
            peek(A_ISR, d); chk("R7 tx level 5", d, 16'h0000);
            chk("R7 irq low", irq_o, 1'b0);
         end
      end
      peek(A_STS, d); chk("R5 tx full status", d, 16'h0000);
      cyc(40);
      peek(A_STS, d); chk("R8 no shift while disabled", d, 16'h0000);
      chk("R8 sclk still", sclk_moves, 0);
      dis_mon = 0;
      wreg(A_CTL, 16'h001F);
      cyc(160);
      peek(A_STS, d); chk("R5 rx full status", d, 16'h000F);
      peek(A_ISR, d); chk("R7 both levels", d, 16'h0003);
      chk("R7 irq high", irq_o, 1'b1);
      for (int i = 1; i <= 8; i++) begin
         popd(d);
         chk($sformatf("R5 order %0d", i), d, 16'(i));
         if (i == 4) begin peek(A_ISR, d); chk("R7 rx level 4", d[0], 1'b1); end
         if (i == 5) begin peek(A_ISR, d); chk("R7 rx level 3", d[0], 1'b0); end
      end
      peek(A_STS, d); chk("R5 ninth dropped", d, 16'h0003);

      // R6 overrun
      wreg(A_CTL, 16'h000F);
      for (int i = 0; i < 8; i++) wreg(A_DAT, 16'h11 + 16'(i));
      wreg(A_CTL, 16'h001F);
      cyc(160);
      wreg(A_DAT, 16'h0019);
      cyc(30);
      peek(A_ISR, d); chk("R6 overrun set", d, 16'h0007);
      for (int i = 0; i < 8; i++) begin
         popd(d);
         chk($sformatf("R6 kept %0d", i), d, 16'h11 + 16'(i));
      end
      peek(A_STS, d); chk("R6 extra discarded", d, 16'h0003);
      peek(A_ISR, d); chk("R6 sticky", d, 16'h0006);
      wreg(A_ISR, 16'h0000);
      peek(A_ISR, d); chk("R6 cleared", d, 16'h0002);

      // R10 / R11
      wreg(A_CTL, 16'h0078);
      peek(A_CTL, d); chk("R11 readback", d, 16'h0078);
      wreg(A_FMT, 16'h0001);
      wreg(A_DAT, 16'hFFFF);
      cyc(30);
      popd(d); chk("R10 width code 1", d, 16'h000F);
      wreg(A_FMT, 16'h0000);
      wreg(A_DAT, 16'h1234);
      cyc(30);
      popd(d); chk("R10 width code 0", d, 16'h0004);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule